// File: doc/BRIEF.md
# Fractional Clock Divider with Triggered Commit

This block divides an input clock by a programmable ratio. The ratio has an integer part and a fraction. Software writes a staged copy of the settings through a small register port. The running divider ignores those writes until software requests a commit. The commit is held pending until the current output period ends. The new settings then take effect at a period boundary, and the pending flag clears, so software can poll for completion. The block can only be committed to while its gate is open.

The divisor field stores one less than the integer divisor. Its lowest bits hold a binary fraction. A phase accumulator as wide as the fraction sums that fraction once per output period. Whenever the accumulator overflows, the period it belongs to is one input cycle longer. The average ratio is therefore the integer divisor plus the fraction. An optional pre-divider stage ahead of the main stage multiplies the whole period by its own integer ratio.

Besides the divided clock, the block drives a strobe that marks the last input cycle of each output period. Logic clocked by the source clock can use this strobe as a clock enable.

Top module: `frac_clk_div`

## Requirements
- R1: After a synchronous active-low reset, all three registers read 0, the divided clock is low and the period strobe is low.
- R2: Register address 1 holds the staged main field. Bits [11:4] hold the integer divisor minus one, and bits [3:0] hold a fraction in sixteenths. The committed setting produces output periods that average (integer+1 + fraction/16) input cycles.
- R3: Periods last either (integer+1) or (integer+2) input cycles. The accumulator is cleared on each commit. Counting periods from k=0 after a commit, period k is the longer one exactly when floor((k+1)*f/16) exceeds floor(k*f/16).
- R4: A write to address 1 or address 2 without a commit changes only the readback value. The running periods keep their length.
- R5: Writing a word with bit 1 and bit 0 set to address 0 starts a commit. Bit 1 of address 0 then reads 1 until the new setting is in use, and reads 0 after that.
- R6: A pending commit takes effect at the end of the output period in progress. That period completes with its old length.
- R7: A commit request written with gate bit 0 of address 0 clear is ignored. The busy bit stays 0. When the gate is opened again, the old setting is still in use.
- R8: Address 2 bits [3:0] hold the pre-divider ratio minus one. Every output period is multiplied by (value+1).
- R9: While gate bit 0 is clear, the divided clock and the strobe stay low. Opening the gate starts a fresh period in the next cycle.
- R10: With a total ratio of one (all fields zero), the divided clock follows the input clock and the strobe is high in every cycle.
- R11: The divided clock is high for the first ceil(L/2) main steps of each period, where L is the period length of the main stage. When L is 1, it is high for the first ceil(P/2) input cycles, where P is the pre-divider ratio.
- R12: The period strobe is high in exactly one input cycle per output period, which is the last one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 main field, 2 pre-divider) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| clk_out | output | 1 | Divided clock |
| period_tick | output | 1 | High in the last source cycle of each output period |

## Verification
The assertions check the following on every cycle:
- A closed gate keeps both outputs low.
- The committed settings change only at a strobe while a commit is pending.
- A pending commit always clears at that strobe.
- A request with the gate closed never sets the busy bit.
- An all-zero setting strobes every cycle.

Only the bench scenarios can show the rest:
- The exact period sequence produced by the fractional dither.
- The multiplication by the pre-divider.
- The high phase of the divided clock.
- The length of the period that was running when a commit was requested.

// File: rtl/frac_clk_div_pkg.sv
// Package: shared register addresses and control bit positions for the
// fractional clock divider. Assumes a two-bit word address.
package frac_clk_div_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MAIN = 2'd1;
    localparam logic [1:0] ADDR_PRE  = 2'd2;

    localparam int CTRL_GATE_BIT = 0;
    localparam int CTRL_TRIG_BIT = 1;

endpackage

// File: rtl/frac_clk_div_regs.sv
// Register file: staged (shadow) and committed (active) divider settings,
// gate bit and commit handshake. A commit request is accepted only when the
// same write also opens the gate. The active copy is loaded from the shadow
// copy when the top signals 'apply' (end of a period with a commit pending).
// Assumes INT_W + FRAC_W <= DATA_W and PRE_W >= 1.
module frac_clk_div_regs
    import frac_clk_div_pkg::*;
#(
    parameter int INT_W   = 8,
    parameter int FRAC_W  = 4,
    parameter int PRE_W   = 4,
    parameter int HAS_PRE = 1,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                apply,
    output logic                gate_en,
    output logic                busy,
    output logic [INT_W-1:0]    act_int,
    output logic [((FRAC_W > 0) ? FRAC_W : 1)-1:0] act_frac,
    output logic [PRE_W-1:0]    act_pre
);

    localparam int FRAC_PW = (FRAC_W > 0) ? FRAC_W : 1;
    localparam int FIELD_W = INT_W + FRAC_W;

    logic                gate_q;
    logic                busy_q;
    logic [INT_W-1:0]    sh_int_q;
    logic [INT_W-1:0]    act_int_q;
    logic [FIELD_W-1:0]  sh_field;
    logic [PRE_W-1:0]    sh_pre;
    logic                wr_ctrl;
    logic                wr_main;
    logic                wr_pre;
    logic                commit_req;
    logic                unused_wdata;

    assign wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_main    = reg_wr && (reg_addr == ADDR_MAIN);
    assign wr_pre     = reg_wr && (reg_addr == ADDR_PRE);
    assign commit_req = wr_ctrl && reg_wdata[CTRL_TRIG_BIT] && reg_wdata[CTRL_GATE_BIT];
    assign unused_wdata = ^reg_wdata;

    // Gate bit and pending-commit flag; a new request wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                gate_q <= reg_wdata[CTRL_GATE_BIT];
            end
            if (commit_req) begin
                busy_q <= 1'b1;
            end else if (apply) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Integer part: staged on write, committed on apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_int_q  <= '0;
            act_int_q <= '0;
        end else begin
            if (wr_main) begin
                sh_int_q <= reg_wdata[FRAC_W +: INT_W];
            end
            if (apply) begin
                act_int_q <= sh_int_q;
            end
        end
    end

    generate
        if (FRAC_W > 0) begin : g_frac
            logic [FRAC_W-1:0] sh_frac_q;
            logic [FRAC_W-1:0] act_frac_q;
            // Fraction part: staged on write, committed on apply.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_frac_q  <= '0;
                    act_frac_q <= '0;
                end else begin
                    if (wr_main) begin
                        sh_frac_q <= reg_wdata[FRAC_W-1:0];
                    end
                    if (apply) begin
                        act_frac_q <= sh_frac_q;
                    end
                end
            end
            assign act_frac = act_frac_q;
            assign sh_field = {sh_int_q, sh_frac_q};
        end else begin : g_int_only
            assign act_frac = '0;
            assign sh_field = sh_int_q;
        end

        if (HAS_PRE != 0) begin : g_pre
            logic [PRE_W-1:0] sh_pre_q;
            logic [PRE_W-1:0] act_pre_q;
            // Pre-divider ratio: staged on write, committed on apply.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_pre_q  <= '0;
                    act_pre_q <= '0;
                end else begin
                    if (wr_pre) begin
                        sh_pre_q <= reg_wdata[PRE_W-1:0];
                    end
                    if (apply) begin
                        act_pre_q <= sh_pre_q;
                    end
                end
            end
            assign act_pre = act_pre_q;
            assign sh_pre  = sh_pre_q;
        end else begin : g_no_pre
            assign act_pre = '0;
            assign sh_pre  = '0;
        end
    endgenerate

    // Readback mux: control flags, staged main field, staged pre-divider.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_GATE_BIT] = gate_q;
                reg_rdata[CTRL_TRIG_BIT] = busy_q;
            end
            ADDR_MAIN: reg_rdata[FIELD_W-1:0] = sh_field;
            ADDR_PRE:  reg_rdata[PRE_W-1:0]   = sh_pre;
            default:   reg_rdata = '0;
        endcase
    end

    assign gate_en = gate_q;
    assign busy    = busy_q;
    assign act_int = act_int_q;

endmodule

// File: rtl/frac_clk_div_prediv.sv
// Pre-divider stage: counts source cycles and marks the last cycle of each
// group of (pre_val+1). With HAS_PRE = 0 it passes every cycle through.
// Assumes pre_val changes only in a cycle where pre_last is high.
module frac_clk_div_prediv #(
    parameter int PRE_W   = 4,
    parameter int HAS_PRE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_val,
    output logic             pre_last,
    output logic             pre_hi,
    output logic             pre_one
);

    generate
        if (HAS_PRE != 0) begin : g_count
            logic [PRE_W-1:0] cnt_q;
            logic [PRE_W:0]   half_up;

            assign half_up  = ({1'b0, pre_val} + (PRE_W+1)'(2)) >> 1;
            assign pre_last = (cnt_q == pre_val);
            assign pre_hi   = ({1'b0, cnt_q} < half_up);
            assign pre_one  = (pre_val == '0);

            // Group counter; held at zero while the gate is closed.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt_q <= '0;
                end else if (pre_last) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end else begin : g_pass
            logic unused_pre;
            assign unused_pre = ^{clk, rst_n, run, pre_val};
            assign pre_last   = 1'b1;
            assign pre_hi     = 1'b1;
            assign pre_one    = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/frac_clk_div_core.sv
// Main divider stage: counts pre-divider steps up to (act_int+1+carry),
// where carry is the overflow of a phase accumulator that adds act_frac once
// per period. The accumulator restarts at zero on a commit and while the
// gate is closed. Assumes act_int/act_frac change only at a period end.
module frac_clk_div_core #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             apply,
    input  logic [INT_W-1:0] act_int,
    input  logic [((FRAC_W > 0) ? FRAC_W : 1)-1:0] act_frac,
    output logic             main_last,
    output logic             main_hi,
    output logic             main_one
);

    localparam int LEN_W = INT_W + 1;

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] last_idx;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] half_up;
    logic             carry;
    logic             period_end;

    assign period_end = run && step && main_last;

    generate
        if (FRAC_W > 0) begin : g_acc
            logic [FRAC_W-1:0] acc_q;
            logic [FRAC_W:0]   sum;

            assign sum   = {1'b0, acc_q} + {1'b0, act_frac};
            assign carry = sum[FRAC_W];

            // Phase accumulator; advances once per completed period.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    acc_q <= '0;
                end else if (period_end) begin
                    acc_q <= apply ? '0 : sum[FRAC_W-1:0];
                end
            end
        end else begin : g_no_acc
            logic unused_frac;
            assign unused_frac = ^{act_frac, apply};
            assign carry = 1'b0;
        end
    endgenerate

    assign last_idx  = {1'b0, act_int} + LEN_W'(carry);
    assign len       = last_idx + LEN_W'(1);
    assign half_up   = (len + LEN_W'(1)) >> 1;
    assign main_last = (cnt_q == last_idx);
    assign main_hi   = (cnt_q < half_up);
    assign main_one  = (last_idx == '0);

    // Step counter within the output period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (step) begin
            if (main_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/frac_clk_div.sv
// Top: fractional clock divider with staged settings and a self-clearing
// commit flag. Chains the pre-divider and main stage, forms the period
// strobe and the divided clock. With a total ratio of one the source clock
// is passed straight through (gated). Assumes one source clock domain.
module frac_clk_div #(
    parameter int INT_W   = 8,
    parameter int FRAC_W  = 4,
    parameter int PRE_W   = 4,
    parameter int HAS_PRE = 1,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_out,
    output logic              period_tick
);

    localparam int FRAC_PW = (FRAC_W > 0) ? FRAC_W : 1;

    logic               gate_en;
    logic               busy;
    logic               apply;
    logic [INT_W-1:0]   act_int;
    logic [FRAC_PW-1:0] act_frac;
    logic [PRE_W-1:0]   act_pre;
    logic               pre_last;
    logic               pre_hi;
    logic               pre_one;
    logic               main_last;
    logic               main_hi;
    logic               main_one;

    frac_clk_div_regs #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W),
        .HAS_PRE(HAS_PRE), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .apply(apply), .gate_en(gate_en), .busy(busy),
        .act_int(act_int), .act_frac(act_frac), .act_pre(act_pre)
    );

    frac_clk_div_prediv #(
        .PRE_W(PRE_W), .HAS_PRE(HAS_PRE)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .run(gate_en),
        .pre_val(act_pre),
        .pre_last(pre_last), .pre_hi(pre_hi), .pre_one(pre_one)
    );

    frac_clk_div_core #(
        .INT_W(INT_W), .FRAC_W(FRAC_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .run(gate_en),
        .step(pre_last), .apply(apply),
        .act_int(act_int), .act_frac(act_frac),
        .main_last(main_last), .main_hi(main_hi), .main_one(main_one)
    );

    assign period_tick = gate_en && pre_last && main_last;
    assign apply       = busy && period_tick;

    // Output clock select: pass-through, pre-stage phase or main-stage phase.
    always_comb begin
        if (!gate_en) begin
            clk_out = 1'b0;
        end else if (main_one && pre_one) begin
            clk_out = clk;
        end else if (main_one) begin
            clk_out = pre_hi;
        end else begin
            clk_out = main_hi;
        end
    end

endmodule

// File: rtl/frac_clk_div_chk.sv
// Checker: cycle-level properties of the commit handshake, the gate and
// the pass-through case. Bound into every frac_clk_div instance.
module frac_clk_div_chk #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int PRE_W  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [1:0]          reg_addr,
    input logic [31:0]         reg_wdata,
    input logic                clk_out,
    input logic                period_tick,
    input logic                gate_en,
    input logic                busy,
    input logic [INT_W-1:0]    act_int,
    input logic [((FRAC_W > 0) ? FRAC_W : 1)-1:0] act_frac,
    input logic [PRE_W-1:0]    act_pre
);

    logic req_seen;
    assign req_seen = reg_wr && (reg_addr == 2'd0) && reg_wdata[1] && reg_wdata[0];

    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> (!period_tick && !clk_out)); // R9

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && period_tick && !req_seen) |=> !busy); // R6

    AST_NO_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_seen) |=> !busy); // R7

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && period_tick) |=> ($stable(act_int) && $stable(act_frac) && $stable(act_pre))); // R4

    AST_BYPASS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && act_int == '0 && act_frac == '0 && act_pre == '0) |-> period_tick); // R10

endmodule

bind frac_clk_div frac_clk_div_chk #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .clk_out(clk_out), .period_tick(period_tick),
    .gate_en(gate_en), .busy(busy),
    .act_int(act_int), .act_frac(act_frac), .act_pre(act_pre)
);

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;
    import frac_clk_div_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    wire  [31:0] reg_rdata;
    wire         clk_out;
    wire         period_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    frac_clk_div uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .clk_out(clk_out), .period_tick(period_tick)
    );

    // {pre-divider value, integer value, fraction}
    localparam int NV = 9;
    localparam int VEC [NV][3] = '{
        '{0, 3, 0}, '{0, 4, 8}, '{0, 2, 4}, '{2, 1, 0}, '{1, 0, 0},
        '{0, 0, 8}, '{3, 2, 15}, '{0, 255, 15}, '{15, 1, 0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        step();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_addr = ADDR_CTRL;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] d;
        n = 0;
        for (int i = 0; i < 20000; i++) begin
            rd(ADDR_CTRL, d);
            if (!d[1]) break;
            n++;
            step();
        end
    endtask

    function automatic int exp_len(int pre, int iv, int f, int k);
        int c;
        c = ((k + 1) * f) / 16 - (k * f) / 16;
        return (pre + 1) * (iv + 1 + c);
    endfunction

    // Starts at cycle 0 of a period; ends on the sample point of the last strobe.
    task automatic measure(input int pre, input int iv, input int f, input int nper,
                           input string req, output int high);
        int c = 0;
        int k = 0;
        int bad_act = 0;
        int bad_exp = 0;
        bit ok = 1'b1;
        high = 0;
        for (int guard = 0; guard < 40000 && k < nper; guard++) begin
            c++;
            if (k == 0 && clk_out) high++;
            if (period_tick) begin
                if (ok && c != exp_len(pre, iv, f, k)) begin
                    ok = 1'b0; bad_act = c; bad_exp = exp_len(pre, iv, f, k);
                end
                k++;
                c = 0;
            end
            if (k < nper) step();
        end
        if (k < nper) begin
            ok = 1'b0; bad_act = k; bad_exp = nper;
        end
        check(ok, req, "period length", bad_act, bad_exp);
    endtask

    task automatic commit(input int pre, input int iv, input int f);
        int n;
        wr(ADDR_PRE, pre);
        wr(ADDR_MAIN, (iv << 4) | f);
        wr(ADDR_CTRL, 32'h3);
        wait_idle(n);
    endtask

    initial begin
        logic [31:0] d;
        int high;
        int n;
        int eh;
        int l0;

        // Reset state (R1)
        repeat (3) step();
        check(clk_out == 1'b0, "R1", "clk_out in reset", clk_out, 0);
        rst_n = 1'b1;
        step();
        rd(ADDR_CTRL, d); check(d == 0, "R1", "control after reset", d, 0);
        rd(ADDR_MAIN, d); check(d == 0, "R1", "main after reset", d, 0);
        rd(ADDR_PRE, d);  check(d == 0, "R1", "pre after reset", d, 0);
        check(clk_out == 1'b0 && period_tick == 1'b0, "R1", "outputs after reset",
              {clk_out, period_tick}, 0);

        // Vector table: encoding R2, dither R3, pre-divider R8, strobe R12, duty R11
        for (int i = 0; i < NV; i++) begin
            commit(VEC[i][0], VEC[i][1], VEC[i][2]);
            measure(VEC[i][0], VEC[i][1], VEC[i][2], 8, "R2 R3 R8 R12", high);
            l0 = VEC[i][1] + 1;
            if (l0 > 1) eh = (VEC[i][0] + 1) * ((l0 + 1) / 2);
            else if (VEC[i][0] > 0) eh = (VEC[i][0] + 2) / 2;
            else eh = 0;
            check(high == eh, "R11", "high cycles in first period", high, eh);
        end

        // Staged write without commit (R4)
        commit(0, 3, 0);
        wr(ADDR_MAIN, 6 << 4);
        rd(ADDR_MAIN, d);
        check(d == (6 << 4), "R4", "staged readback", d, 6 << 4);
        while (!period_tick) step();
        step();
        measure(0, 3, 0, 3, "R4", high);

        // Closed gate keeps outputs low (R9)
        wr(ADDR_CTRL, 32'h0);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            if (clk_out || period_tick) n++;
            @(posedge clk); #1;
            if (clk_out || period_tick) n++;
            step();
        end
        check(n == 0, "R9", "activity while gated", n, 0);

        // Commit request with gate bit clear is ignored (R7)
        wr(ADDR_CTRL, 32'h2);
        rd(ADDR_CTRL, d);
        check(d[1] == 1'b0, "R7", "busy after gated request", d[1], 0);
        wr(ADDR_CTRL, 32'h1);
        measure(0, 3, 0, 3, "R7 R9", high);

        // Commit waits for the end of the running period (R5, R6)
        commit(0, 9, 0);
        wr(ADDR_MAIN, 2 << 4);
        while (!period_tick) step();
        wr(ADDR_CTRL, 32'h3);
        rd(ADDR_CTRL, d);
        check(d[1] == 1'b1, "R5", "busy reads 1 while pending", d[1], 1);
        wait_idle(n);
        check(n == 9, "R6", "cycles until commit applied", n, 9);
        rd(ADDR_CTRL, d);
        check(d[1] == 1'b0, "R5", "busy reads 0 after apply", d[1], 0);
        measure(0, 2, 0, 4, "R6", high);

        // Ratio of one passes the source clock (R10)
        commit(0, 0, 0);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            if (!period_tick || clk_out) n++;
            @(posedge clk); #1;
            if (!clk_out) n++;
            step();
        end
        check(n == 0, "R10", "pass-through mismatches", n, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL WATCHDOG run did not complete actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule